// File: doc/BRIEF.md
# Banked Flash Mapper with SD Card SPI Window

This block sits between a CPU bus and a large flash device and gives the CPU four switchable 8 KB windows in the range 0x4000-0xBFFF. Each window is backed by one of four 8-bit bank registers. An ordinary access in that range is turned into a flash address inside a 1 MB region that starts at flash byte 0x700000. Only the low seven bank bits count, so the upper half of the bank numbers repeats the lower half. A CPU write anywhere in 0x6000-0x7FFF loads one bank register. Address bits 12:11 pick which register.

When bank register 0 carries the pattern 01 in its two top bits, the first window (0x4000-0x5FFF) stops showing flash to reads and becomes a port to two SD card sockets. Reads and most writes in that window run one 8-bit SPI exchange. Address bit 12 of the access decides whether the chosen card's chip select is driven active. A write to the top quarter of the window picks the socket instead. During an exchange the block holds `cpu_wait` high. It then pulses `cpu_done` together with the result.

The access sequencer has three states. ACC_IDLE takes a strobe. The transition ACC_IDLE→ACC_ACK serves any non-exchange access. The transition ACC_IDLE→ACC_SHIFT starts an exchange. ACC_SHIFT→ACC_ACK fires on the last serial bit. ACC_ACK→ACC_IDLE always follows one cycle later. The serial engine also has three states. SH_IDLE→SH_LOW fires on start. SH_LOW→SH_HIGH raises the clock after DIV cycles. SH_HIGH→SH_LOW lowers the clock after DIV cycles for bits 0-6. SH_HIGH→SH_IDLE does the same after bit 7.

Top module: `sd_bank_mapper`

## Requirements
- R1: After reset the bank registers hold 0, 1, 0, 0 (windows 0x4000, 0x6000, 0x8000, 0xA000). After reset socket 1 is selected, both `spi_cs_n` bits are high, `spi_sclk` is low, and `cpu_wait` and `cpu_done` are low.
- R2: A CPU write in 0x6000-0x7FFF stores the data byte in bank register `cpu_addr[12:11]` (0 to 3).
- R3: A read in 0x4000-0xBFFF that is not in an active card window pulses `flash_rd` in the strobe cycle. The flash address is 0x700000 + (bank & 0x7F)·0x2000 + (addr & 0x1FFF). The window index is `cpu_addr[15:13]` minus 2. `cpu_rdata` holds the flash byte in the cycle after the strobe, while `cpu_done` is high.
- R4: A read outside 0x4000-0xBFFF returns 0xFF with `cpu_done` one cycle after the strobe and raises no `flash_rd`.
- R5: Every write in 0x4000-0xBFFF pulses `flash_wr` with `flash_wdata` = data. Its address uses the bank values in force before that same write updates any bank register. Writes in an active card window are included.
- R6: The card window is active only when bank register 0 bits 7:6 equal 01. It covers 0x4000-0x5FFF only. With any other top-bit pattern that range reads flash.
- R7: Every read in an active window runs an SPI exchange. So does every write to its 0x4000-0x57FF part. An exchange is 8 bits in mode 0, MSB first, with SCLK low and high for DIV cycles each. `cpu_wait` is high for exactly 16·DIV cycles, then `cpu_done` pulses for one cycle.
- R8: An exchange with `cpu_addr[12]` = 0 drives the selected socket's chip select low. An exchange with `cpu_addr[12]` = 1 drives it high. The level holds after the exchange. The other socket's chip select stays high (bit 0 is socket 1, bit 1 is socket 2).
- R9: A write to 0x5800-0x5FFF in an active window sets the socket from data bit 0 (0 = socket 1, 1 = socket 2). It starts no exchange.
- R10: A read exchange shifts out 0xFF and returns the byte taken from MISO. A write exchange shifts out the data byte, and `cpu_rdata` reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_stb | input | 1 | One-cycle access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_rdata | output | 8 | Read result, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_wait | output | 1 | High while an SPI exchange is running |
| flash_addr | output | 23 | Flash byte address |
| flash_rd | output | 1 | Flash read strobe |
| flash_wr | output | 1 | Flash write strobe |
| flash_wdata | output | 8 | Flash write data |
| flash_rdata | input | 8 | Flash read data |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to card |
| spi_miso | input | 1 | SPI data from card |
| spi_cs_n | output | 2 | Active-low chip selects, bit 0 socket 1 |

## Verification
The bench writes a bank register with an address whose own window maps through that register. A design that updated the bank before forming the flash address would send the write to the new bank. It also loads bank values with bit 7 set and uses the top bank number 0x7F. These catch a lost mirror mask or a bad offset, which show up as a flash address outside the 1 MB region. The card window is tried both with a non-matching top-bit pattern and with the matching one. An exchange that ran without the pattern, or a window read that still strobed flash, would be seen. Chip-select level, socket choice and the exact wait length are checked on every exchange. This catches an inverted bit 12, a socket write that also clocks the card, or an off-by-one divider.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_SHIFT,
        ACC_ACK
    } acc_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_state_t;
endpackage

// File: rtl/sdm_bank_regs.sv
module sdm_bank_regs #(
    parameter int NBANK = 4,
    parameter int BW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NBANK)-1:0]   sel,
    input  logic [BW-1:0]              wdata,
    output logic [NBANK-1:0][BW-1:0]   banks
);
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [BW-1:0] INIT = (g == 1) ? BW'(1) : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                banks[g] <= INIT;
            else if (wr_en && sel == g)
                banks[g] <= wdata;
        end
    end

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> banks[$past(sel)] == $past(wdata));
endmodule

// File: rtl/sdm_decode.sv
module sdm_decode #(
    parameter int                 FLASH_AW    = 23,
    parameter logic [FLASH_AW-1:0] FLASH_BASE = 23'h700000,
    parameter int                 MIRROR_BITS = 7
) (
    input  logic [15:0]          addr,
    input  logic [3:0][7:0]      banks,
    output logic                 in_range,
    output logic                 window,
    output logic                 bank_hit,
    output logic                 socket_hit,
    output logic [FLASH_AW-1:0]  flash_addr
);
    localparam int OFF_W = MIRROR_BITS + 13;

    logic [1:0] idx;
    logic [7:0] sel_bank;
    logic       unused_bank_msb;

    always_comb begin
        in_range   = (addr >= 16'h4000) && (addr < 16'hC000);
        idx        = addr[14:13] ^ 2'b10;
        sel_bank   = banks[idx];
        window     = (banks[0][7:6] == 2'b01) && (addr[15:13] == 3'b010);
        bank_hit   = (addr[15:13] == 3'b011);
        socket_hit = window && (addr[12:11] == 2'b11);
        flash_addr = FLASH_BASE +
                     FLASH_AW'(OFF_W'({sel_bank[MIRROR_BITS-1:0], addr[12:0]}));
        unused_bank_msb = sel_bank[7];
    end
endmodule

// File: rtl/sdm_spi_shift.sv
module sdm_spi_shift
    import sdm_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    sh_state_t   state, nstate;
    logic [CW-1:0] cnt;
    logic [2:0]  bitn;
    logic [7:0]  sh;
    logic        miso_q;
    logic        tick;

    assign tick = (cnt == LAST);

    always_comb begin
        nstate = state;
        unique case (state)
            SH_IDLE: if (start) nstate = SH_LOW;
            SH_LOW:  if (tick)  nstate = SH_HIGH;
            SH_HIGH: if (tick)  nstate = (bitn == 3'd7) ? SH_IDLE : SH_LOW;
            default: nstate = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SH_IDLE;
        else
            state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            bitn   <= '0;
            sh     <= 8'hFF;
            miso_q <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: if (start) begin
                    sh   <= tx;
                    cnt  <= '0;
                    bitn <= '0;
                end
                SH_LOW: begin
                    cnt <= tick ? '0 : cnt + 1'b1;
                    if (tick) miso_q <= miso;
                end
                SH_HIGH: begin
                    cnt <= tick ? '0 : cnt + 1'b1;
                    if (tick) begin
                        sh   <= {sh[6:0], miso_q};
                        bitn <= bitn + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sclk = (state == SH_HIGH);
    assign mosi = sh[7];
    assign done = (state == SH_HIGH) && tick && (bitn == 3'd7);
    assign rx   = {sh[6:0], miso_q};

    // R7
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/sd_bank_mapper.sv
module sd_bank_mapper
    import sdm_pkg::*;
#(
    parameter int DIV      = 2,
    parameter int FLASH_AW = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                cpu_stb,
    input  logic                cpu_we,
    output logic [7:0]          cpu_rdata,
    output logic                cpu_done,
    output logic                cpu_wait,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic                flash_rd,
    output logic                flash_wr,
    output logic [7:0]          flash_wdata,
    input  logic [7:0]          flash_rdata,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [1:0]          spi_cs_n
);
    acc_state_t     state, nstate;
    logic [3:0][7:0] banks;
    logic in_range, window, bank_hit, socket_hit;
    logic accept, xchg, we_q, sh_done, sock, cs_on;
    logic [7:0] rx;

    sdm_bank_regs #(.NBANK(4), .BW(8)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && cpu_we && bank_hit),
        .sel(cpu_addr[12:11]), .wdata(cpu_wdata), .banks(banks)
    );

    sdm_decode #(.FLASH_AW(FLASH_AW), .FLASH_BASE(FLASH_AW'(24'h700000)),
                 .MIRROR_BITS(7)) u_dec (
        .addr(cpu_addr), .banks(banks), .in_range(in_range), .window(window),
        .bank_hit(bank_hit), .socket_hit(socket_hit), .flash_addr(flash_addr)
    );

    sdm_spi_shift #(.DIV(DIV)) u_spi (
        .clk(clk), .rst_n(rst_n), .start(xchg),
        .tx(cpu_we ? cpu_wdata : 8'hFF), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(rx)
    );

    assign accept      = cpu_stb && (state == ACC_IDLE);
    assign xchg        = accept && window && !(cpu_we && socket_hit);
    assign flash_wr    = accept && cpu_we && in_range;
    assign flash_rd    = accept && !cpu_we && in_range && !window;
    assign flash_wdata = cpu_wdata;

    always_comb begin
        nstate = state;
        unique case (state)
            ACC_IDLE:  if (accept) nstate = xchg ? ACC_SHIFT : ACC_ACK;
            ACC_SHIFT: if (sh_done) nstate = ACC_ACK;
            ACC_ACK:   nstate = ACC_IDLE;
            default:   nstate = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ACC_IDLE;
        else
            state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rdata <= 8'hFF;
            we_q      <= 1'b0;
            sock      <= 1'b0;
            cs_on     <= 1'b0;
        end else begin
            unique case (state)
                ACC_IDLE: if (accept) begin
                    we_q      <= cpu_we;
                    cpu_rdata <= (!cpu_we && in_range && !window) ? flash_rdata : 8'hFF;
                    if (cpu_we && socket_hit) sock  <= cpu_wdata[0];
                    if (xchg)                 cs_on <= ~cpu_addr[12];
                end
                ACC_SHIFT: if (sh_done) cpu_rdata <= we_q ? 8'hFF : rx;
                default: ;
            endcase
        end
    end

    assign cpu_wait = (state == ACC_SHIFT);
    assign cpu_done = (state == ACC_ACK);
    assign spi_cs_n = ~({sock, ~sock} & {2{cs_on}});

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));
    // R7
    sclk_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> cpu_wait);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    // R4
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && !in_range) |=> (cpu_done && cpu_rdata == 8'hFF));
endmodule

// File: tb/tb_sd_bank_mapper.sv
`timescale 1ns/1ps
module tb_sd_bank_mapper;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_stb = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_done, cpu_wait;
    logic [22:0] flash_addr;
    logic        flash_rd, flash_wr;
    logic [7:0]  flash_wdata, flash_rdata;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;

    always #2.5 clk = ~clk;

    sd_bank_mapper #(.DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stb(cpu_stb), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .cpu_done(cpu_done), .cpu_wait(cpu_wait), .flash_addr(flash_addr),
        .flash_rd(flash_rd), .flash_wr(flash_wr), .flash_wdata(flash_wdata),
        .flash_rdata(flash_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    function automatic logic [7:0] fdata(logic [22:0] a);
        return a[7:0] ^ a[20:13];
    endfunction
    assign flash_rdata = fdata(flash_addr);

    // card model
    logic [7:0] slv_tx = 8'h00;
    logic [7:0] slv_rx = 8'h00;
    logic [2:0] slv_cnt = 3'd0;
    logic [1:0] cs_seen = 2'b11;
    int         rises = 0;
    assign spi_miso = slv_tx[3'd7 - slv_cnt];
    always @(posedge spi_sclk) begin
        slv_rx  <= {slv_rx[6:0], spi_mosi};
        slv_cnt <= slv_cnt + 3'd1;
        if (slv_cnt == 3'd0) cs_seen <= spi_cs_n;
        rises   <= rises + 1;
    end

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    int         wait_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && cpu_wait) wait_cnt <= wait_cnt + 1;
        if (rst_n && cpu_done) begin
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected done", 1, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cpu_rdata == e, t, "rdata", cpu_rdata, e);
            end
        end
    end

    logic [22:0] s_fa;
    logic        s_rd, s_wr;
    logic [7:0]  s_wd;

    task automatic access(logic [15:0] a, bit we, logic [7:0] d,
                          logic [7:0] exp, string tag);
        @(negedge clk);
        cpu_addr = a; cpu_we = we; cpu_wdata = d; cpu_stb = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        wait_cnt = 0;
        #1;
        s_fa = flash_addr; s_rd = flash_rd; s_wr = flash_wr; s_wd = flash_wdata;
        @(negedge clk);
        cpu_stb = 1'b0; cpu_we = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic flash_read(logic [15:0] a, logic [22:0] fa, string tag);
        access(a, 0, 8'h00, fdata(fa), tag);
        check(s_rd == 1'b1, tag, "flash_rd", s_rd, 1);
        check(s_fa == fa, tag, "flash_addr", s_fa, fa);
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 2'b11, "R1", "cs_n", spi_cs_n, 3);
        check(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
        check(cpu_wait == 1'b0 && cpu_done == 1'b0, "R1", "wait/done", {cpu_wait, cpu_done}, 0);
        // R1 R3 reset bank contents
        flash_read(16'h4010, 23'h700010, "R1");
        flash_read(16'h6005, 23'h702005, "R1");
        flash_read(16'hA000, 23'h700000, "R1");
        // R4 out of range
        access(16'h2000, 0, 8'h00, 8'hFF, "R4");
        check(s_rd == 1'b0, "R4", "flash_rd low", s_rd, 0);
        access(16'hC123, 0, 8'h00, 8'hFF, "R4");
        check(s_rd == 1'b0, "R4", "flash_rd low", s_rd, 0);
        // R2 R5: write bank2 through window 1 (bank1=1)
        access(16'h7000, 1, 8'h85, 8'hFF, "R2");
        check(s_wr && s_fa == 23'h703000 && s_wd == 8'h85, "R5", "flash_wr addr", s_fa, 23'h703000);
        // R3 mirror of 0x85
        flash_read(16'h8123, 23'h70A123, "R3");
        // R5 write to bank1 uses old bank1
        access(16'h6800, 1, 8'h10, 8'hFF, "R2");
        check(s_wr && s_fa == 23'h702800, "R5", "pre-update addr", s_fa, 23'h702800);
        flash_read(16'h6000, 23'h720000, "R2");
        // R2 R3 top bank
        access(16'h7800, 1, 8'h7F, 8'hFF, "R2");
        flash_read(16'hBFFF, 23'h7FFFFF, "R3");
        // R6 pattern 10 is not a window
        access(16'h6000, 1, 8'h80, 8'hFF, "R2");
        r0 = rises;
        flash_read(16'h4000, 23'h700000, "R6");
        check(rises == r0, "R6", "no sclk", rises - r0, 0);
        // R6 enable window
        access(16'h6000, 1, 8'h40, 8'hFF, "R2");
        // R7 R8 R10 write exchange on socket 1
        r0 = rises;
        access(16'h4000, 1, 8'hA5, 8'hFF, "R10");
        check(s_wr && s_fa == 23'h780000, "R5", "window write to flash", s_fa, 23'h780000);
        check(wait_cnt == 16 * DIV, "R7", "wait cycles", wait_cnt, 16 * DIV);
        check(rises - r0 == 8, "R7", "sclk rises", rises - r0, 8);
        check(slv_rx == 8'hA5, "R10", "mosi byte", slv_rx, 8'hA5);
        check(cs_seen == 2'b10, "R8", "cs during", cs_seen, 2);
        check(spi_cs_n == 2'b10, "R8", "cs held", spi_cs_n, 2);
        // R10 read exchange
        slv_tx = 8'h3C;
        access(16'h4100, 0, 8'h00, 8'h3C, "R10");
        check(s_rd == 1'b0, "R6", "no flash_rd in window", s_rd, 0);
        check(slv_rx == 8'hFF, "R10", "read sends FF", slv_rx, 8'hFF);
        check(wait_cnt == 16 * DIV, "R7", "wait cycles rd", wait_cnt, 16 * DIV);
        // R8 bit12 high deasserts
        slv_tx = 8'hC3;
        access(16'h5000, 0, 8'h00, 8'hC3, "R10");
        check(cs_seen == 2'b11, "R8", "cs deasserted", cs_seen, 3);
        check(spi_cs_n == 2'b11, "R8", "cs held high", spi_cs_n, 3);
        // R9 socket 2
        r0 = rises;
        access(16'h5800, 1, 8'h01, 8'hFF, "R9");
        check(rises == r0 && wait_cnt == 0, "R9", "no exchange", rises - r0, 0);
        access(16'h4000, 1, 8'h5A, 8'hFF, "R9");
        check(cs_seen == 2'b01, "R9", "socket 2 cs", cs_seen, 1);
        check(slv_rx == 8'h5A, "R10", "mosi byte s2", slv_rx, 8'h5A);
        // R9 back to socket 1
        access(16'h5900, 1, 8'h00, 8'hFF, "R9");
        slv_tx = 8'h81;
        access(16'h4000, 0, 8'h00, 8'h81, "R9");
        check(cs_seen == 2'b10, "R9", "socket 1 cs", cs_seen, 2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule